// File: doc/BRIEF.md
# PCI Slot Hotplug Register Controller

This block keeps three per-slot bitmaps for one PCI bus of up to 32 slots:
- which slots hold a device;
- which slots may be hot-swapped;
- which slots have a removal pending.

Firmware reaches the bitmaps through a 16-byte window of four dword registers. The window is served by a plain select/write/address/data port with combinational read data.

The platform reports slot events with a slot number and a two-bit kind code: coldplug, hot insert or hot unplug. Hot events produce a one-cycle set pulse toward a general-purpose event block, which holds the sticky status bit. Firmware acknowledges a removal by writing the eject register. The block then services only the lowest slot named in the written value, and it signals the removal logic with an eject pulse that carries the slot index.

A platform reset request makes the block work through every pending removal, one per cycle, in ascending slot order. It then rebuilds two bitmaps:
- hotplug capability, from a "not hot-swappable" mask;
- presence, from the mask of devices currently attached.

Power-on reset runs the same rebuild with nothing pending.

Top module: `slot_hotplug_regs`

## Requirements
- R1: Aligned dword reads decode the register window from address bits [3:2]. Offset 0x0 returns "up", 0x4 returns the pending-removal bitmap, 0x8 returns zero and 0xC returns the hotplug-capable bitmap. A read with address bits [1:0] not zero returns zero.
- R2: Only an aligned write to offset 0x8 changes state. Writes to 0x0, 0x4, 0xC and misaligned writes are ignored.
- R3: The "up" register reads as the presence bitmap ANDed with the hotplug-capable bitmap.
- R4: An eject write selects the lowest set bit of the written data and clears that slot's pending-removal bit. If the slot is hotplug-capable, the write also clears its presence bit, and one cycle later the block raises `ejectValid` for one cycle with `ejectSlot` set to the slot index. Writing zero changes nothing.
- R5: An eject write that selects a slot without hotplug capability clears only the pending-removal bit. Presence is kept and no eject pulse is produced.
- R6: The event kind code 2'b10 (hot insert) sets the slot's presence bit. One cycle after the event is sampled, `gpeSetPulse` is high for one cycle.
- R7: The event kind code 2'b11 (hot unplug) sets the slot's pending-removal bit and raises `gpeSetPulse` with the same timing as R6.
- R8: The event kind code 2'b01 (coldplug) sets the presence bit and raises no `gpeSetPulse`. The kind code 2'b00 does nothing.
- R9: When an event and an eject write are sampled in the same cycle, the event is applied after the eject. An unplug of the slot being ejected therefore leaves its pending bit set, and an insert of that slot leaves its presence bit set.
- R10: While `rstN` is low, "up" and the pending bitmap read zero and the capable bitmap reads all ones. Within two cycles after release, presence equals `attachedMask` and the capable bitmap equals the inverse of `noHotplugMask`.
- R11: A `platRst` pulse sampled while idle starts a flush. Each cycle, the lowest pending slot is ejected with the R4/R5 rules, giving eject pulses in ascending slot order. When nothing is pending, presence and capability are rebuilt as in R10. Events and eject writes during the flush are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| platRst | input | 1 | Platform reset request pulse: flush pending removals and rebuild |
| ioSel | input | 1 | Register access in this cycle |
| ioWrite | input | 1 | 1 = write, 0 = read |
| ioAddr | input | 4 | Byte offset in the register window |
| ioWdata | input | 32 | Write data |
| ioRdata | output | 32 | Read data (combinational, zero when not reading) |
| evtValid | input | 1 | Slot event present |
| evtKind | input | 2 | 01 coldplug, 10 hot insert, 11 hot unplug |
| evtSlot | input | 5 | Slot number of the event |
| attachedMask | input | 32 | Slots with a device attached, used at rebuild |
| noHotplugMask | input | 32 | Slots that may not be hot-swapped |
| ejectValid | output | 1 | One-cycle eject request |
| ejectSlot | output | 5 | Slot index qualified by ejectValid |
| gpeSetPulse | output | 1 | One-cycle set of the hotplug status bit |

## Verification
The bench targets four kinds of mistake:
- **Several bits in one eject write.** A design that cleared every written bit, or the highest one, shows up as extra cleared pending bits or a wrong eject index.
- **Eject write and event of the same slot in one cycle.** Applying the two in the wrong order loses a fresh unplug or insert.
- **Slots without hotplug capability.** A design that ignored capability would raise eject pulses or drop presence for them.
- **The platform-reset flush.** Out-of-order or repeated pulses, pulses for incapable slots, events that leak through mid-flush, and a stale bitmap left after the rebuild all reach the port checks.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    EVT_NONE   = 2'b00,
    EVT_COLD   = 2'b01,
    EVT_HOT    = 2'b10,
    EVT_UNPLUG = 2'b11
  } evt_kind_e;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_FLUSH   = 2'd1,
    SEQ_REBUILD = 2'd2
  } seq_state_e;

  // register index = address bits [3:2]
  localparam logic [1:0] RIDX_UP    = 2'd0;
  localparam logic [1:0] RIDX_DOWN  = 2'd1;
  localparam logic [1:0] RIDX_EJECT = 2'd2;
  localparam logic [1:0] RIDX_RMV   = 2'd3;

  typedef struct packed {
    logic      wrEject;
    logic      flushEject;
    logic      applyEvt;
    evt_kind_e evtKind;
    logic      rebuild;
  } hp_strobe_t;
endpackage

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
  import slot_hp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       platRst,
  input  logic       ioSel,
  input  logic       ioWrite,
  input  logic [3:0] ioAddr,
  input  logic       evtValid,
  input  logic [1:0] evtKind,
  input  logic       downEmpty,
  output hp_strobe_t strb,
  output logic       rdEn,
  output logic [1:0] rdReg
);
  seq_state_e stateQ, stateN;
  logic aligned, idle;

  assign aligned = (ioAddr[1:0] == 2'b00);
  assign idle    = (stateQ == SEQ_IDLE);

  always_comb begin
    stateN = stateQ;
    case (stateQ)
      SEQ_IDLE:    if (platRst) stateN = SEQ_FLUSH;
      SEQ_FLUSH:   if (downEmpty) stateN = SEQ_REBUILD;
      SEQ_REBUILD: stateN = SEQ_IDLE;
      default:     stateN = SEQ_IDLE;
    endcase
  end

  // power-on reset enters the flush so that the rebuild runs once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SEQ_FLUSH;
    else       stateQ <= stateN;
  end

  always_comb begin
    strb.wrEject    = idle && ioSel && ioWrite && aligned && (ioAddr[3:2] == RIDX_EJECT);
    strb.flushEject = (stateQ == SEQ_FLUSH) && !downEmpty;
    strb.applyEvt   = idle && evtValid && (evt_kind_e'(evtKind) != EVT_NONE);
    strb.evtKind    = evt_kind_e'(evtKind);
    strb.rebuild    = (stateQ == SEQ_REBUILD);
  end

  assign rdEn  = ioSel && !ioWrite && aligned;
  assign rdReg = ioAddr[3:2];

  // R11
  flush_done_before_rebuild_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rebuild |-> downEmpty);

  // R11
  flush_holds_until_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SEQ_FLUSH && !downEmpty) |=> (stateQ == SEQ_FLUSH));
endmodule

// File: rtl/slot_hp_datapath.sv
module slot_hp_datapath
  import slot_hp_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hp_strobe_t           strb,
  input  logic [REG_W-1:0]     ejWdata,
  input  logic [SLOT_W-1:0]    evtSlot,
  input  logic [NUM_SLOTS-1:0] attachedMask,
  input  logic [NUM_SLOTS-1:0] noHotplugMask,
  input  logic                 rdEn,
  input  logic [1:0]           rdReg,
  output logic [REG_W-1:0]     rdata,
  output logic                 downEmpty,
  output logic                 ejectValid,
  output logic [SLOT_W-1:0]    ejectSlot,
  output logic                 gpeSetPulse
);
  localparam logic [NUM_SLOTS-1:0] ONE = NUM_SLOTS'(1);

  logic [NUM_SLOTS-1:0] presQ, downQ, hpEnQ;
  logic [NUM_SLOTS-1:0] presN, downN;
  logic [NUM_SLOTS-1:0] ejVec, ejOne;
  logic [SLOT_W-1:0]    ejIdx;
  logic                 ejectValidQ, gpeQ;
  logic [SLOT_W-1:0]    ejectSlotQ;

  // eject source: pending bitmap during a flush, else write data
  always_comb begin
    ejVec = '0;
    if (strb.flushEject)   ejVec = downQ;
    else if (strb.wrEject) ejVec = ejWdata[NUM_SLOTS-1:0];
  end

  assign ejOne = ejVec & ((~ejVec) + ONE);

  always_comb begin
    ejIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (ejVec[i]) ejIdx = SLOT_W'(i);
    end
  end

  // per-slot next state: eject first, then the event, rebuild overrides
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic evHit, evIns, evDrop, ejHit;
    assign ejHit  = ejOne[s];
    assign evHit  = strb.applyEvt && (evtSlot == SLOT_W'(s));
    assign evIns  = evHit && ((strb.evtKind == EVT_COLD) || (strb.evtKind == EVT_HOT));
    assign evDrop = evHit && (strb.evtKind == EVT_UNPLUG);
    assign downN[s] = (downQ[s] && !ejHit) || evDrop;
    assign presN[s] = strb.rebuild ? attachedMask[s]
                                   : ((presQ[s] && !(ejHit && hpEnQ[s])) || evIns);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presQ       <= '0;
      downQ       <= '0;
      hpEnQ       <= '1;
      ejectValidQ <= 1'b0;
      ejectSlotQ  <= '0;
      gpeQ        <= 1'b0;
    end else begin
      presQ       <= presN;
      downQ       <= downN;
      if (strb.rebuild) hpEnQ <= ~noHotplugMask;
      ejectValidQ <= |(ejOne & hpEnQ);
      ejectSlotQ  <= ejIdx;
      gpeQ        <= strb.applyEvt && (strb.evtKind != EVT_COLD);
    end
  end

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      case (rdReg)
        RIDX_UP:    rdata = REG_W'(presQ & hpEnQ);
        RIDX_DOWN:  rdata = REG_W'(downQ);
        RIDX_EJECT: rdata = '0;
        RIDX_RMV:   rdata = REG_W'(hpEnQ);
        default:    rdata = '0;
      endcase
    end
  end

  assign downEmpty   = ~|downQ;
  assign ejectValid  = ejectValidQ;
  assign ejectSlot   = ejectSlotQ;
  assign gpeSetPulse = gpeQ;

  // R6
  gpe_pulse_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    gpeSetPulse |-> $past(strb.applyEvt && strb.evtKind != EVT_COLD));

  // R8
  cold_no_gpe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.applyEvt && strb.evtKind == EVT_COLD) |=> !gpeSetPulse);

  // R4
  eject_clears_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|ejOne) && !(strb.applyEvt && strb.evtKind == EVT_UNPLUG && evtSlot == ejIdx))
      |=> !downQ[$past(ejIdx)]);

  // R5
  nonhp_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(ejOne & ~hpEnQ)) |=> !ejectValid);

  // R10
  rebuild_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rebuild |=> (presQ == $past(attachedMask)) && (hpEnQ == ~$past(noHotplugMask)));
endmodule

// File: rtl/slot_hotplug_regs.sv
module slot_hotplug_regs
  import slot_hp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        platRst,
  input  logic        ioSel,
  input  logic        ioWrite,
  input  logic [3:0]  ioAddr,
  input  logic [31:0] ioWdata,
  output logic [31:0] ioRdata,
  input  logic        evtValid,
  input  logic [1:0]  evtKind,
  input  logic [4:0]  evtSlot,
  input  logic [31:0] attachedMask,
  input  logic [31:0] noHotplugMask,
  output logic        ejectValid,
  output logic [4:0]  ejectSlot,
  output logic        gpeSetPulse
);
  hp_strobe_t strb;
  logic       rdEn, downEmpty;
  logic [1:0] rdReg;

  slot_hp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .platRst   (platRst),
    .ioSel     (ioSel),
    .ioWrite   (ioWrite),
    .ioAddr    (ioAddr),
    .evtValid  (evtValid),
    .evtKind   (evtKind),
    .downEmpty (downEmpty),
    .strb      (strb),
    .rdEn      (rdEn),
    .rdReg     (rdReg)
  );

  slot_hp_datapath #(.NUM_SLOTS(32), .SLOT_W(5)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .ejWdata       (ioWdata),
    .evtSlot       (evtSlot),
    .attachedMask  (attachedMask),
    .noHotplugMask (noHotplugMask),
    .rdEn          (rdEn),
    .rdReg         (rdReg),
    .rdata         (ioRdata),
    .downEmpty     (downEmpty),
    .ejectValid    (ejectValid),
    .ejectSlot     (ejectSlot),
    .gpeSetPulse   (gpeSetPulse)
  );
endmodule

// File: tb/tb_slot_hotplug_regs.sv
`timescale 1ns/1ps
module tb_slot_hotplug_regs;
  logic clk = 1'b0;
  logic rstN, platRst, ioSel, ioWrite, evtValid;
  logic [3:0]  ioAddr;
  logic [31:0] ioWdata, ioRdata, attachedMask, noHotplugMask;
  logic [1:0]  evtKind;
  logic [4:0]  evtSlot, ejectSlot;
  logic        ejectValid, gpeSetPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [31:0] presM, downM, hpM;

  always #2 clk = ~clk;

  slot_hotplug_regs dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] lowIdx(input logic [31:0] v);
    logic [4:0] r = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = 5'(i);
    return r;
  endfunction

  function automatic logic [31:0] expRead(input logic [3:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[3:2])
      2'd0: return presM & hpM;
      2'd1: return downM;
      2'd2: return 32'h0;
      default: return hpM;
    endcase
  endfunction

  task automatic idleIn();
    ioSel = 0; ioWrite = 0; ioAddr = 0; ioWdata = 0;
    evtValid = 0; evtKind = 0; evtSlot = 0; platRst = 0;
  endtask

  // one clock: drive at negedge, check read before edge, pulses after
  task automatic doCycle(input logic sel, input logic wr, input logic [3:0] addr,
                         input logic [31:0] wd, input logic ev, input logic [1:0] kind,
                         input logic [4:0] slot, input string tag);
    logic [31:0] nP, nD, one;
    logic expEj, expGpe;
    logic [4:0] expSlot;
    ioSel = sel; ioWrite = wr; ioAddr = addr; ioWdata = wd;
    evtValid = ev; evtKind = kind; evtSlot = slot;
    #1;
    if (sel && !wr) check({tag, " R1/R3 read"}, ioRdata, expRead(addr));
    nP = presM; nD = downM; expEj = 0; expGpe = 0; expSlot = 0;
    if (sel && wr && addr == 4'h8 && wd != 0) begin
      one = wd & (~wd + 32'd1);
      nD = nD & ~one;
      if ((hpM & one) != 0) begin
        nP = nP & ~one; expEj = 1; expSlot = lowIdx(wd);
      end
    end
    if (ev && kind != 2'b00) begin
      if (kind == 2'b11) nD[slot] = 1'b1;
      else nP[slot] = 1'b1;
      expGpe = (kind != 2'b01);
    end
    @(negedge clk);
    check({tag, " R4/R5 ejectValid"}, 32'(ejectValid), 32'(expEj));
    if (expEj) check({tag, " R4 ejectSlot"}, 32'(ejectSlot), 32'(expSlot));
    check({tag, " R6/R7/R8 gpeSetPulse"}, 32'(gpeSetPulse), 32'(expGpe));
    presM = nP; downM = nD;
    idleIn();
  endtask

  task automatic readAll(input string tag);
    for (int a = 0; a < 16; a += 4) doCycle(1, 0, 4'(a), 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 4);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rem, newAtt;
    int pulses;
    bit gpeSeen;
    void'($urandom(32'd20240611));
    idleIn();
    attachedMask  = 32'h0F0F_00F3;
    noHotplugMask = 32'h0001_0401;   // slots 0, 10, 16 not hot-swappable
    rstN = 0;
    presM = 0; downM = 0; hpM = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    // R10 reset state, read while reset held
    ioSel = 1; ioAddr = 4'h0; #1; check("R10 reset up", ioRdata, 32'h0);
    ioAddr = 4'h4; #1; check("R10 reset down", ioRdata, 32'h0);
    ioAddr = 4'hC; #1; check("R10 reset capable", ioRdata, 32'hFFFF_FFFF);
    idleIn();
    rstN = 1;
    repeat (3) @(negedge clk);
    presM = attachedMask; hpM = ~noHotplugMask;
    doCycle(1, 0, 4'h0, 0, 0, 0, 0, "R10 rebuilt up");
    doCycle(1, 0, 4'hC, 0, 0, 0, 0, "R10 rebuilt capable");

    doCycle(0, 0, 0, 0, 1, 2'b10, 5'd2, "R6 hot insert");
    doCycle(1, 0, 4'h0, 0, 0, 0, 0, "R6 up after insert");
    doCycle(0, 0, 0, 0, 1, 2'b01, 5'd3, "R8 coldplug");
    doCycle(0, 0, 0, 0, 1, 2'b00, 5'd8, "R8 null kind");
    doCycle(1, 0, 4'h0, 0, 0, 0, 0, "R8 up after cold");
    doCycle(0, 0, 0, 0, 1, 2'b11, 5'd5, "R7 unplug");
    doCycle(0, 0, 0, 0, 1, 2'b11, 5'd0, "R7 unplug nonhp");
    doCycle(1, 0, 4'h4, 0, 0, 0, 0, "R7 down");
    doCycle(1, 1, 4'h8, 32'h21, 0, 0, 0, "R5 eject nonhp lowest");
    readAll("R5 after");
    doCycle(1, 1, 4'h8, 32'h20, 0, 0, 0, "R4 eject slot5");
    doCycle(1, 1, 4'h8, 32'h0, 0, 0, 0, "R4 eject zero");
    readAll("R4 after");
    doCycle(0, 0, 0, 0, 1, 2'b11, 5'd7, "R9 prep");
    doCycle(1, 1, 4'h8, 32'h80, 1, 2'b11, 5'd7, "R9 eject+unplug");
    doCycle(1, 1, 4'h8, 32'h80, 1, 2'b10, 5'd7, "R9 eject+insert");
    readAll("R9 after");
    doCycle(1, 1, 4'h0, 32'hFFFF_FFFF, 0, 0, 0, "R2 wr up");
    doCycle(1, 1, 4'h4, 32'hFFFF_FFFF, 0, 0, 0, "R2 wr down");
    doCycle(1, 1, 4'hC, 32'h0, 0, 0, 0, "R2 wr capable");
    doCycle(1, 1, 4'h9, 32'hFFFF_FFFF, 0, 0, 0, "R2 misaligned eject");
    readAll("R2 after");
    doCycle(1, 0, 4'h6, 0, 0, 0, 0, "R1 misaligned read");

    for (int n = 0; n < 3000; n++) begin
      int op = $urandom % 6;
      logic [31:0] v = $urandom & $urandom & $urandom;
      logic [4:0] sl = 5'($urandom);
      logic [1:0] k = 2'($urandom);
      case (op)
        0, 1: doCycle(1, 0, 4'($urandom), 0, 0, 0, 0, "rand");
        2: doCycle(1, 1, 4'h8, v, 0, 0, 0, "R4 rand eject");
        3: doCycle(1, 1, 4'($urandom), v, 1, k, sl, "R2 rand write+evt");
        4: doCycle(1, 1, 4'h8, 32'h1 << sl, 1, k, sl, "R9 rand same slot");
        default: doCycle(0, 0, 0, 0, 1, k, sl, "R6 rand evt");
      endcase
    end

    // R11 flush
    doCycle(0, 0, 0, 0, 1, 2'b11, 5'd4, "R11 prep");
    doCycle(0, 0, 0, 0, 1, 2'b11, 5'd10, "R11 prep");
    doCycle(0, 0, 0, 0, 1, 2'b11, 5'd20, "R11 prep");
    newAtt = 32'h3300_A00C;
    attachedMask = newAtt;
    rem = downM & hpM;
    platRst = 1;
    @(negedge clk);
    platRst = 0;
    pulses = 0; gpeSeen = 0;
    for (int c = 0; c < 40; c++) begin
      if (c < 2) begin
        evtValid = 1; evtKind = 2'b11; evtSlot = 5'd30;
        ioSel = 1; ioWrite = 1; ioAddr = 4'h8; ioWdata = 32'h4000_0000;
      end else idleIn();
      @(negedge clk);
      if (gpeSetPulse) gpeSeen = 1;
      if (ejectValid) begin
        check("R11 flush order", 32'(ejectSlot), 32'(lowIdx(rem)));
        rem[ejectSlot] = 1'b0;
        pulses++;
      end
    end
    idleIn();
    check("R11 all capable pending ejected", rem, 32'h0);
    check("R11 no gpe during flush", 32'(gpeSeen), 32'h0);
    downM = 0; presM = newAtt;
    readAll("R11 after rebuild");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule